// File: doc/BRIEF.md
# Floppy Controller Host Command Sequencer

This block is the processor side of a floppy disc controller. The processor sees two byte-wide registers. One is a read-only main status byte that shows whether the controller is ready, which way the next byte flows, and which phase is active. The other is a data register. Through the data register the processor writes a command byte and that command's parameter bytes, then reads back the result bytes.

The sequencer decodes the opcode held in the low five bits of the command byte and counts the parameter bytes that opcode needs. It then starts an execution engine with a one-cycle pulse that carries the opcode, the three mode flags and the parameter bytes. When the engine strobes done, the sequencer latches its result bytes and hands them to the processor one at a time. Two cases are answered locally with a single error status byte and no engine start: an opcode it does not recognise, and a sense-interrupt request made while no interrupt is pending. After each accepted byte, the ready flag stays low for a configurable number of cycles.

Top module: `fdc_host_seq`

## Requirements
- R1: The opcode is `wdata_i[4:0]` of the command byte. `flags_o` presents command bits 7..5 (multi-track, MFM, skip) and `opcode_o` presents the opcode while `start_o` is high.
- R2: The parameter byte count is 8 for opcodes 0x02, 0x05, 0x06, 0x09, 0x0C, 0x11, 0x19 and 0x1D. It is 5 for 0x0D, 2 for 0x0F and 0x03, 1 for 0x07, 0x04 and 0x0A, and 0 for 0x08. `start_o` pulses for exactly one cycle, in the cycle after the last parameter byte is accepted (after the command byte itself when the count is 0). Parameter k appears on `params_o[8k+7:8k]`.
- R3: The result byte count is 7 for the eight 8-parameter opcodes and for 0x0A and 0x0D, 2 for 0x08, and 1 for 0x04. On `done_i` these bytes are latched, and result k, taken from `res_i[8k+7:8k]`, is read in order of increasing k.
- R4: Status bits: bit 7 is ready, bit 6 is direction (1 = controller to processor), bit 5 is execution active, bit 4 is command in progress, and bits 3..0 read 0. The status is 0x80 when idle, 0x90 while collecting parameters, 0x30 during execution and 0xD0 while results are pending (ready flag permitting).
- R5: A command byte is not accepted until every result byte of the previous command has been read. Writes during the result phase have no effect.
- R6: An opcode outside the R2 list produces no start pulse and a single result byte, 0x80.
- R7: Opcode 0x08 with `irq_pend_i` low produces no start pulse and a single result byte, 0x80. With `irq_pend_i` high it starts the engine and returns 2 bytes.
- R8: A data-register write is ignored while ready is low or direction is 1. A read is ignored unless the result phase is active with ready high.
- R9: After each accepted write or read, ready stays low for exactly HOLD_CYC cycles and then returns.
- R10: After reset the status reads 0x80 and `start_o` is low.
- R11: Opcodes 0x03, 0x07 and 0x0F return no result bytes. On `done_i` the sequencer goes straight back to idle (status 0x80).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 8 | Data register write byte |
| rd_i | input | 1 | Data register read strobe |
| rdata_o | output | 8 | Data register read byte (current result) |
| msr_o | output | 8 | Main status byte |
| irq_pend_i | input | 1 | An interrupt is pending for sense-interrupt |
| start_o | output | 1 | One-cycle engine start |
| opcode_o | output | 5 | Decoded opcode |
| flags_o | output | 3 | Command bits 7..5 |
| params_o | output | 64 | Parameter bytes, byte k at bits 8k+7..8k |
| done_i | input | 1 | Engine completion strobe |
| res_i | input | 56 | Engine result bytes, byte k at bits 8k+7..8k |

## Verification
The assertions check on every cycle that the start pulse lasts one cycle and falls inside the execution phase, that the direction and execution flags only appear with the busy flag, that ready drops after every accepted transfer, and that a write cannot end the result phase. Only the bench scenarios can show the per-opcode byte counts, the order and values of results, the locally generated 0x80 responses, the exact length of the ready holdoff, and that ignored writes leave the parameters and results untouched.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  localparam int MAX_PAR = 8;
  localparam int MAX_RES = 7;
  localparam int PAR_W   = $clog2(MAX_PAR + 1);
  localparam int RES_W   = $clog2(MAX_RES + 1);
  localparam logic [7:0] ST0_BAD_CMD = 8'h80;

  typedef enum logic [4:0] {
    OP_RD_TRACK = 5'h02, OP_SPECIFY = 5'h03, OP_SNS_DRV = 5'h04,
    OP_WR_DATA  = 5'h05, OP_RD_DATA = 5'h06, OP_RECAL   = 5'h07,
    OP_SNS_INT  = 5'h08, OP_WR_DEL  = 5'h09, OP_RD_ID   = 5'h0A,
    OP_RD_DEL   = 5'h0C, OP_FORMAT  = 5'h0D, OP_SEEK    = 5'h0F,
    OP_SCAN_EQ  = 5'h11, OP_SCAN_LE = 5'h19, OP_SCAN_HE = 5'h1D
  } opcode_e;

  typedef enum logic [1:0] {PH_CMD, PH_PARAM, PH_EXEC, PH_RESULT} phase_e;
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_seq_pkg::*;
(
  input  logic [4:0]       op_i,
  output logic             valid_o,
  output logic             sns_int_o,
  output logic [PAR_W-1:0] npar_o,
  output logic [RES_W-1:0] nres_o
);
  always_comb begin
    valid_o = 1'b1;
    npar_o  = '0;
    nres_o  = '0;
    unique case (op_i)
      OP_RD_DATA, OP_RD_DEL, OP_WR_DATA, OP_WR_DEL, OP_RD_TRACK,
      OP_SCAN_EQ, OP_SCAN_LE, OP_SCAN_HE: begin
        npar_o = PAR_W'(8); nres_o = RES_W'(7);
      end
      OP_FORMAT:  begin npar_o = PAR_W'(5); nres_o = RES_W'(7); end
      OP_RD_ID:   begin npar_o = PAR_W'(1); nres_o = RES_W'(7); end
      OP_SEEK:    npar_o = PAR_W'(2);
      OP_SPECIFY: npar_o = PAR_W'(2);
      OP_RECAL:   npar_o = PAR_W'(1);
      OP_SNS_DRV: begin npar_o = PAR_W'(1); nres_o = RES_W'(1); end
      OP_SNS_INT: nres_o = RES_W'(2);
      default:    valid_o = 1'b0;
    endcase
  end
  assign sns_int_o = (op_i == OP_SNS_INT);
endmodule

// File: rtl/fdc_ready_timer.sv
module fdc_ready_timer #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic ready_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (kick_i)        cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf
  import fdc_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [RES_W-1:0]     load_cnt_i,
  input  logic [MAX_RES*8-1:0] load_data_i,
  input  logic                 pop_i,
  output logic [7:0]           head_o,
  output logic                 last_o
);
  logic [7:0]       sr_q [MAX_RES];
  logic [RES_W-1:0] rem_q;

  for (genvar i = 0; i < MAX_RES; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sr_q[i] <= '0;
      else if (load_i) sr_q[i] <= load_data_i[8*i +: 8];
      else if (pop_i) begin
        if (i == MAX_RES - 1) sr_q[i] <= '0;
        else                  sr_q[i] <= sr_q[(i + 1) % MAX_RES];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rem_q <= '0;
    else if (load_i)                 rem_q <= load_cnt_i;
    else if (pop_i && rem_q != '0)   rem_q <= rem_q - 1'b1;
  end

  assign head_o = sr_q[0];
  assign last_o = (rem_q == RES_W'(1));
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
  import fdc_seq_pkg::*;
#(
  parameter int HOLD_CYC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 rd_i,
  output logic [7:0]           rdata_o,
  output logic [7:0]           msr_o,
  input  logic                 irq_pend_i,
  output logic                 start_o,
  output logic [4:0]           opcode_o,
  output logic [2:0]           flags_o,
  output logic [MAX_PAR*8-1:0] params_o,
  input  logic                 done_i,
  input  logic [MAX_RES*8-1:0] res_i
);
  localparam int IDX_W = $clog2(MAX_PAR);

  phase_e           ph_q;
  logic             start_q;
  logic [4:0]       op_q;
  logic [2:0]       flg_q;
  logic [7:0]       par_q [MAX_PAR];
  logic [IDX_W-1:0] pidx_q;
  logic [PAR_W-1:0] npar_q;
  logic [RES_W-1:0] nres_q;

  logic             dec_valid, dec_sns;
  logic [PAR_W-1:0] dec_npar;
  logic [RES_W-1:0] dec_nres;
  logic             ready, rqm, dio, wr_ok, rd_ok, last_par;
  logic             buf_load, buf_last;
  logic [RES_W-1:0] buf_cnt;
  logic [MAX_RES*8-1:0] buf_data;
  logic             cmd_err;

  fdc_cmd_decode u_dec (
    .op_i(wdata_i[4:0]), .valid_o(dec_valid), .sns_int_o(dec_sns),
    .npar_o(dec_npar), .nres_o(dec_nres)
  );

  assign rqm   = ready && (ph_q != PH_EXEC);
  assign dio   = (ph_q == PH_RESULT);
  assign wr_ok = wr_i && rqm && !dio;
  assign rd_ok = rd_i && rqm && dio;

  fdc_ready_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk_i, .rst_ni, .kick_i(wr_ok || rd_ok), .ready_o(ready)
  );

  // local error answer: unknown opcode or sense-interrupt with nothing pending
  assign cmd_err  = (ph_q == PH_CMD) && wr_ok && (!dec_valid || (dec_sns && !irq_pend_i));
  assign last_par = ({1'b0, pidx_q} == PAR_W'(npar_q - 1'b1));
  assign buf_load = cmd_err || ((ph_q == PH_EXEC) && done_i && nres_q != '0);
  assign buf_cnt  = cmd_err ? RES_W'(1) : nres_q;
  assign buf_data = cmd_err ? {{(MAX_RES-1)*8{1'b0}}, ST0_BAD_CMD} : res_i;

  fdc_result_buf u_res (
    .clk_i, .rst_ni, .load_i(buf_load), .load_cnt_i(buf_cnt),
    .load_data_i(buf_data), .pop_i(rd_ok), .head_o(rdata_o), .last_o(buf_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_CMD;
      start_q <= 1'b0;
      op_q    <= '0;
      flg_q   <= '0;
      pidx_q  <= '0;
      npar_q  <= '0;
      nres_q  <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (ph_q)
        PH_CMD: if (wr_ok) begin
          op_q   <= wdata_i[4:0];
          flg_q  <= wdata_i[7:5];
          pidx_q <= '0;
          npar_q <= dec_npar;
          nres_q <= dec_nres;
          if (cmd_err)              ph_q <= PH_RESULT;
          else if (dec_npar == '0) begin
            ph_q    <= PH_EXEC;
            start_q <= 1'b1;
          end else                  ph_q <= PH_PARAM;
        end
        PH_PARAM: if (wr_ok) begin
          if (last_par) begin
            ph_q    <= PH_EXEC;
            start_q <= 1'b1;
          end else pidx_q <= pidx_q + 1'b1;
        end
        PH_EXEC: if (done_i) ph_q <= (nres_q == '0) ? PH_CMD : PH_RESULT;
        PH_RESULT: if (rd_ok && buf_last) ph_q <= PH_CMD;
        default: ph_q <= PH_CMD;
      endcase
    end
  end

  for (genvar k = 0; k < MAX_PAR; k++) begin : g_par
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     par_q[k] <= '0;
      else if (ph_q == PH_CMD && wr_ok)                par_q[k] <= '0;
      else if (ph_q == PH_PARAM && wr_ok && pidx_q == IDX_W'(k)) par_q[k] <= wdata_i;
    end
    assign params_o[8*k +: 8] = par_q[k];
  end

  assign start_o  = start_q;
  assign opcode_o = op_q;
  assign flags_o  = flg_q;
  assign msr_o    = {rqm, dio, (ph_q == PH_EXEC), (ph_q != PH_CMD), 4'b0000};
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] msr_o,
  input logic       start_o
);
  p_start_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_in_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (msr_o[5] && !msr_o[7]));
  p_dir_needs_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_o[6] |-> msr_o[4]);
  p_exec_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_o[5] |-> (msr_o[4] && !msr_o[6] && !msr_o[7]));
  p_wr_holdoff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && msr_o[7] && !msr_o[6]) |=> !msr_o[7]);
  p_rd_holdoff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && msr_o[7] && msr_o[6]) |=> !msr_o[7]);
  p_wr_keeps_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_o[6] && wr_i && !rd_i) |=> msr_o[6]);
endmodule

bind fdc_host_seq fdc_host_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
  .msr_o(msr_o), .start_o(start_o)
);

// File: tb/sim_fdc_host_seq.sv
module sim_fdc_host_seq;
  localparam int HOLD = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, pend = 1'b0, done = 1'b0;
  logic [7:0]  wdata = '0, rdata, msr;
  logic        start;
  logic [4:0]  opcode;
  logic [2:0]  flags;
  logic [63:0] params;
  logic [55:0] res = '0;

  int n_chk = 0, n_bad = 0;
  logic last_start;

  always #2.5 clk = ~clk;

  fdc_host_seq #(.HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .msr_o(msr), .irq_pend_i(pend), .start_o(start),
    .opcode_o(opcode), .flags_o(flags), .params_o(params),
    .done_i(done), .res_i(res)
  );

  function automatic int exp_npar(input logic [4:0] op);
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D: return 8;
      5'h0D: return 5;
      5'h0F, 5'h03: return 2;
      5'h07, 5'h04, 5'h0A: return 1;
      5'h08: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_nres(input logic [4:0] op);
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D, 5'h0D, 5'h0A: return 7;
      5'h08: return 2;
      5'h04: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic raw_wr(input logic [7:0] b);
    @(negedge clk); wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0; last_start = start;
  endtask

  task automatic wait_msr(input logic [1:0] want);
    for (int i = 0; i < 50; i++) begin
      if (msr[7:6] == want) break;
      @(negedge clk);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wait_msr(2'b10);
    raw_wr(b);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    wait_msr(2'b11);
    b = rdata;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input bit p);
    logic [4:0]  op = cmd[4:0];
    int          np = exp_npar(op);
    int          nr;
    logic [63:0] pexp = '0;
    logic [55:0] rv;
    logic [7:0]  b;
    bit          local_err = (np < 0) || (op == 5'h08 && !p);
    pend = p;
    wr_byte(cmd);
    for (int k = 0; k < np; k++) begin
      b = 8'($urandom);
      pexp[8*k +: 8] = b;
      wr_byte(b);
    end
    if (local_err) begin
      chk(!last_start, "R6/R7 no start", 64'(last_start), 0);
      wait_msr(2'b11);
      chk(msr == 8'hD0, "R6/R7 result status", msr, 8'hD0);
      rd_byte(b);
      chk(b == 8'h80, "R6/R7 error byte", b, 8'h80);
    end else begin
      chk(last_start, "R2 start after last param", 64'(last_start), 1);
      chk(opcode == op && flags == cmd[7:5], "R1 opcode/flags", {opcode, flags}, {op, cmd[7:5]});
      chk(params == pexp, "R2 params", params, pexp);
      @(negedge clk);
      chk(!start, "R2 start one cycle", 64'(start), 0);
      chk(msr == 8'h30, "R4 exec status", msr, 8'h30);
      raw_wr(8'hA5);
      chk(params == pexp && msr == 8'h30, "R8 write in exec ignored", params, pexp);
      repeat (HOLD + ($urandom % 3)) @(negedge clk);
      rv = {$urandom, $urandom};
      nr = exp_nres(op);
      res = rv; done = 1'b1;
      @(negedge clk); done = 1'b0; res = '0;
      if (nr == 0) begin
        chk(msr == 8'h80, "R11 back to idle", msr, 8'h80);
      end else begin
        chk(msr == 8'hD0, "R4 result status", msr, 8'hD0);
        for (int k = 0; k < nr; k++) begin
          rd_byte(b);
          chk(b == rv[8*k +: 8], "R3 result byte", b, rv[8*k +: 8]);
        end
      end
    end
    repeat (HOLD + 1) @(negedge clk);
    chk(msr == 8'h80, "R3 idle after results", msr, 8'h80);
  endtask

  localparam logic [4:0] VALID_OPS [15] = '{5'h02, 5'h03, 5'h04, 5'h05, 5'h06,
    5'h07, 5'h08, 5'h09, 5'h0A, 5'h0C, 5'h0D, 5'h0F, 5'h11, 5'h19, 5'h1D};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(msr == 8'h80 && !start, "R10 reset state", {start, msr}, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msr == 8'h80, "R10 after reset", msr, 8'h80);

    // R9: holdoff after command byte of a specify
    raw_wr(8'h03);
    chk(msr == 8'h10, "R9 ready low cycle 1", msr, 8'h10);
    @(negedge clk); chk(!msr[7], "R9 ready low cycle 2", msr, 8'h10);
    @(negedge clk); chk(!msr[7], "R9 ready low cycle 3", msr, 8'h10);
    @(negedge clk); chk(msr == 8'h90, "R9 ready back", msr, 8'h90);
    // R8: write while ready low is dropped
    raw_wr(8'h11);
    @(negedge clk); wr = 1'b1; wdata = 8'hEE;
    @(negedge clk); wr = 1'b0;
    wr_byte(8'h22);
    chk(params[15:0] == 16'h2211, "R8 write during holdoff ignored", params[15:0], 16'h2211);
    chk(last_start && opcode == 5'h03, "R2 specify start", {last_start, opcode}, {1'b1, 5'h03});
    repeat (HOLD + 1) @(negedge clk);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk(msr == 8'h80, "R11 specify no results", msr, 8'h80);

    // R8: read in idle ignored
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk(msr == 8'h80, "R8 idle read ignored", msr, 8'h80);

    run_cmd(8'hFF, 1'b0);   // R6 invalid opcode 0x1F
    run_cmd(8'h00, 1'b0);   // R6 invalid opcode 0x00
    run_cmd(8'h08, 1'b0);   // R7 sense interrupt, none pending
    run_cmd(8'h08, 1'b1);   // R7 sense interrupt, pending
    run_cmd(8'hE6, 1'b0);   // R1 flags on read data

    // R5: command write during result phase ignored
    wr_byte(8'h04); wr_byte(8'h01);
    repeat (HOLD + 1) @(negedge clk);
    res = 56'h5A; done = 1'b1; @(negedge clk); done = 1'b0;
    wait_msr(2'b11);
    raw_wr(8'h08);
    repeat (HOLD + 1) @(negedge clk);
    chk(msr == 8'hD0 && rdata == 8'h5A, "R5 result held against write", {msr, rdata}, 16'hD05A);
    rd_byte(b);
    chk(b == 8'h5A, "R3 sense drive byte", b, 8'h5A);
    repeat (HOLD + 1) @(negedge clk);
    chk(msr == 8'h80, "R5 idle after last read", msr, 8'h80);

    for (int i = 0; i < 60; i++) begin
      logic [7:0] c;
      if ($urandom % 5 == 0) c = 8'($urandom);
      else c = {3'($urandom), VALID_OPS[$urandom % 15]};
      run_cmd(c, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule